// File: doc/BRIEF.md
# Shared CAN Message Buffer Memory

This block is the word-addressed storage that a host processor and a CAN controller both use to exchange frames. It holds fifteen message buffers of eight 16-bit words each. A sixteenth bank of eight words is reserved. Both sides reach the single storage array through their own request port. Each port can write a whole word or single bytes, and reads always return a whole word. A fixed-priority arbiter picks one port per cycle. The CAN side always wins a tie. A processor access that loses waits, with its request held, until the first cycle in which the CAN side is idle.

The CAN side drives one busy flag per buffer. A buffer is busy while the controller copies a received frame into it, or while that buffer is queued for sending. While its flag is set, processor writes to the buffer's identifier, payload and timestamp words are dropped without any indication. Processor writes to the buffer's control/status word and processor reads of any word still go through. The CAN port is never gated by the busy flags. Every grant is answered by a one-cycle ready pulse on that port one cycle later, and the read data is valid in that same cycle.

Top module: `canmb_shared_ram`

## Requirements
- R1: A word written at address a = 8*buffer + offset (buffer 0..14, offset 0..7) reads back unchanged from either port. Offset 0 is the control/status word, offset 1 the timestamp, offsets 2..5 payload words, offsets 6..7 identifier words.
- R2: Byte enable bit 1 selects data bits 15:8 and bit 0 selects bits 7:0. A write changes only the enabled bytes.
- R3: A request on a port with no competing request is granted in the same cycle. The port's ready is high in the next cycle.
- R4: When both ports request, the CAN port is granted and the processor port sees no ready. The processor is granted in the first cycle without a CAN request.
- R5: The two ports are never granted in the same cycle.
- R6: While busy[n] is 1, processor writes to offsets 1..7 of buffer n leave the word unchanged. Other buffers and CAN-port writes are unaffected.
- R7: Processor writes to offset 0 of a buffer take effect even while its busy flag is 1.
- R8: Processor reads of any word of a busy buffer return the stored contents.
- R9: Addresses 120..255 cover the reserved bank and everything past it. On both ports they read as zero, and writes to them change no stored word.
- R10: A port's read data changes only in the cycle after a read granted to that port, and otherwise holds.
- R11: Ready is a single-cycle pulse: it is high only in the cycle after a grant to that port.
- R12: After reset both ready outputs and both read-data outputs are 0, and every stored word reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_be | input | 2 | Processor byte enables for writes |
| cpu_addr | input | 8 | Processor word address |
| cpu_wdata | input | 16 | Processor write data |
| cpu_rdata | output | 16 | Processor read data, valid with ready |
| cpu_rdy | output | 1 | Processor access completed pulse |
| can_req | input | 1 | CAN-side access request |
| can_we | input | 1 | CAN-side write (1) or read (0) |
| can_be | input | 2 | CAN-side byte enables for writes |
| can_addr | input | 8 | CAN-side word address |
| can_wdata | input | 16 | CAN-side write data |
| can_rdata | output | 16 | CAN-side read data, valid with ready |
| can_rdy | output | 1 | CAN-side access completed pulse |
| buf_busy | input | 15 | Per-buffer busy flags from the CAN side |

## Verification
The bench targets these cases:
- **Busy flags.** It writes a payload word of a busy buffer, then of a different busy buffer, then the busy buffer's control/status word. A design that decoded the buffer number wrongly would block the wrong buffer. A design that forgot the control-word exception would lose the status update.
- **Address boundaries.** It writes at the reserved bank and at an address whose low seven bits alias a real word. A design that truncated the address would then show corrupted data at the aliased word.
- **Sustained contention.** It holds a CAN request for two cycles against a waiting processor read. A design that alternated ties, or granted both ports, would show an early processor ready or stale data.
- **Ready and read data.** After a grant it checks that ready drops again and that read data holds through the other port's traffic.

// File: rtl/canmb_pkg.sv
package canmb_pkg;
  localparam int CMB_NBUF  = 15;
  localparam int CMB_WPB   = 8;
  localparam int CMB_DW    = 16;
  localparam int CMB_AW    = 8;
  localparam int CMB_WORDS = CMB_NBUF * CMB_WPB;
  localparam int CMB_BE_W  = CMB_DW / 8;
  localparam int CMB_OFF_W = $clog2(CMB_WPB);
  localparam int CMB_BNK_W = CMB_AW - CMB_OFF_W;
  localparam int CMB_IDX_W = $clog2(CMB_WORDS);

  typedef logic [CMB_AW-1:0]   cmb_addr_t;
  typedef logic [CMB_DW-1:0]   cmb_word_t;
  typedef logic [CMB_BE_W-1:0] cmb_be_t;
  typedef logic [CMB_NBUF-1:0] cmb_busy_t;

  localparam logic [CMB_OFF_W-1:0] CMB_CTRL_OFF = '0;

  function automatic logic f_in_store(cmb_addr_t a);
    return int'(a) < CMB_WORDS;
  endfunction

  function automatic logic [CMB_BNK_W-1:0] f_bank(cmb_addr_t a);
    return a[CMB_AW-1:CMB_OFF_W];
  endfunction

  function automatic logic [CMB_OFF_W-1:0] f_off(cmb_addr_t a);
    return a[CMB_OFF_W-1:0];
  endfunction

  function automatic logic [CMB_IDX_W-1:0] f_idx(cmb_addr_t a);
    return a[CMB_IDX_W-1:0];
  endfunction

  // Processor write permission: storage range, control word always open,
  // other words closed while the owning buffer is busy.
  function automatic logic f_cpu_wr_ok(cmb_addr_t a, cmb_busy_t busy);
    if (!f_in_store(a)) return 1'b0;
    if (f_off(a) == CMB_CTRL_OFF) return 1'b1;
    for (int i = 0; i < CMB_NBUF; i++)
      if (busy[i] && (int'(f_bank(a)) == i)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic cmb_word_t f_merge(cmb_word_t old_w, cmb_word_t new_w, cmb_be_t be);
    cmb_word_t r = old_w;
    for (int b = 0; b < CMB_BE_W; b++)
      if (be[b]) r[b*8 +: 8] = new_w[b*8 +: 8];
    return r;
  endfunction
endpackage

// File: rtl/canmb_arb.sv
module canmb_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_req,
  input  logic can_req,
  output logic cpu_gnt,
  output logic can_gnt,
  output logic cpu_rdy,
  output logic can_rdy
);
  // Fixed priority: the CAN side never waits.
  assign can_gnt = can_req;
  assign cpu_gnt = cpu_req & ~can_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_rdy <= 1'b0;
      can_rdy <= 1'b0;
    end else begin
      cpu_rdy <= cpu_gnt;
      can_rdy <= can_gnt;
    end
  end
endmodule

// File: rtl/canmb_wqual.sv
module canmb_wqual
  import canmb_pkg::*;
(
  input  logic      is_can,
  input  cmb_addr_t addr,
  input  cmb_busy_t busy,
  output logic      in_store,
  output logic      wr_ok
);
  assign in_store = f_in_store(addr);
  assign wr_ok    = is_can ? in_store : f_cpu_wr_ok(addr, busy);
endmodule

// File: rtl/canmb_store.sv
module canmb_store
  import canmb_pkg::*;
#(
  parameter int DEPTH = CMB_WORDS,
  parameter int IW    = CMB_IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  cmb_be_t       be,
  input  logic [IW-1:0] idx,
  input  cmb_word_t     wdata,
  output cmb_word_t     rword
);
  cmb_word_t mem [DEPTH];
  logic      idx_ok;

  assign idx_ok = int'(idx) < DEPTH;
  assign rword  = idx_ok ? mem[idx] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && idx_ok) begin
      mem[idx] <= f_merge(mem[idx], wdata, be);
    end
  end
endmodule

// File: rtl/canmb_shared_ram.sv
module canmb_shared_ram
  import canmb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_req,
  input  logic                cpu_we,
  input  logic [CMB_BE_W-1:0] cpu_be,
  input  logic [CMB_AW-1:0]   cpu_addr,
  input  logic [CMB_DW-1:0]   cpu_wdata,
  output logic [CMB_DW-1:0]   cpu_rdata,
  output logic                cpu_rdy,
  input  logic                can_req,
  input  logic                can_we,
  input  logic [CMB_BE_W-1:0] can_be,
  input  logic [CMB_AW-1:0]   can_addr,
  input  logic [CMB_DW-1:0]   can_wdata,
  output logic [CMB_DW-1:0]   can_rdata,
  output logic                can_rdy,
  input  logic [CMB_NBUF-1:0] buf_busy
);
  // Named internal events, observed by the bound checker.
  logic      cpu_gnt, can_gnt, any_gnt;
  logic      acc_we, in_store, wr_ok, store_we, cpu_wr_blocked;
  cmb_addr_t acc_addr;
  cmb_be_t   acc_be;
  cmb_word_t acc_wdata, store_rword, rd_word;
  cmb_word_t cpu_rdata_q, can_rdata_q;

  canmb_arb u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .cpu_req (cpu_req),
    .can_req (can_req),
    .cpu_gnt (cpu_gnt),
    .can_gnt (can_gnt),
    .cpu_rdy (cpu_rdy),
    .can_rdy (can_rdy)
  );

  assign any_gnt   = cpu_gnt | can_gnt;
  assign acc_addr  = can_gnt ? can_addr  : cpu_addr;
  assign acc_we    = can_gnt ? can_we    : cpu_we;
  assign acc_be    = can_gnt ? can_be    : cpu_be;
  assign acc_wdata = can_gnt ? can_wdata : cpu_wdata;

  canmb_wqual u_wqual (
    .is_can   (can_gnt),
    .addr     (acc_addr),
    .busy     (buf_busy),
    .in_store (in_store),
    .wr_ok    (wr_ok)
  );

  assign store_we       = any_gnt & acc_we & wr_ok;
  assign cpu_wr_blocked = cpu_gnt & cpu_we & in_store & ~wr_ok;

  canmb_store u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (store_we),
    .be    (acc_be),
    .idx   (f_idx(acc_addr)),
    .wdata (acc_wdata),
    .rword (store_rword)
  );

  assign rd_word = in_store ? store_rword : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_rdata_q <= '0;
      can_rdata_q <= '0;
    end else begin
      if (cpu_gnt && !cpu_we) cpu_rdata_q <= rd_word;
      if (can_gnt && !can_we) can_rdata_q <= rd_word;
    end
  end

  assign cpu_rdata = cpu_rdata_q;
  assign can_rdata = can_rdata_q;
endmodule

// File: rtl/canmb_shared_ram_chk.sv
module canmb_shared_ram_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_req,
  input logic        cpu_we,
  input logic [7:0]  cpu_addr,
  input logic [15:0] cpu_rdata,
  input logic        cpu_rdy,
  input logic        can_req,
  input logic        can_rdy,
  input logic [14:0] buf_busy,
  input logic        cpu_gnt,
  input logic        can_gnt,
  input logic        store_we
);
  localparam int LIMIT = 120;
  logic [15:0] busy_x;
  logic        cpu_in, cpu_busy_hit;
  assign busy_x       = {1'b0, buf_busy};
  assign cpu_in       = int'(cpu_addr) < LIMIT;
  assign cpu_busy_hit = busy_x[cpu_addr[6:3]];

  p_uncontended_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !can_req) |=> cpu_rdy);
  p_can_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    can_req |=> (can_rdy && !cpu_rdy));
  p_one_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_gnt && can_gnt));
  p_busy_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_gnt && cpu_we && cpu_in && cpu_addr[2:0] != 3'd0 && cpu_busy_hit) |-> !store_we);
  p_ctrl_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_gnt && cpu_we && cpu_in && cpu_addr[2:0] == 3'd0) |-> store_we);
  p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_gnt && !cpu_we && !cpu_in) |=> (cpu_rdata == 16'h0));
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_gnt && !cpu_we) |=> $stable(cpu_rdata));
  p_rdy_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_gnt |=> !cpu_rdy);
endmodule

bind canmb_shared_ram canmb_shared_ram_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_req   (cpu_req),
  .cpu_we    (cpu_we),
  .cpu_addr  (cpu_addr),
  .cpu_rdata (cpu_rdata),
  .cpu_rdy   (cpu_rdy),
  .can_req   (can_req),
  .can_rdy   (can_rdy),
  .buf_busy  (buf_busy),
  .cpu_gnt   (cpu_gnt),
  .can_gnt   (can_gnt),
  .store_we  (store_we)
);

// File: tb/canmb_shared_ram_tb_top.sv
module canmb_shared_ram_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [1:0]  cpu_be = 2'b00;
  logic [7:0]  cpu_addr = 8'h0;
  logic [15:0] cpu_wdata = 16'h0;
  logic [15:0] cpu_rdata;
  logic        cpu_rdy;
  logic        can_req = 1'b0, can_we = 1'b0;
  logic [1:0]  can_be = 2'b00;
  logic [7:0]  can_addr = 8'h0;
  logic [15:0] can_wdata = 16'h0;
  logic [15:0] can_rdata;
  logic        can_rdy;
  logic [14:0] buf_busy = 15'h0;

  always #2.5 clk = ~clk;

  canmb_shared_ram dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_be(cpu_be), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_rdy(cpu_rdy),
    .can_req(can_req), .can_we(can_we), .can_be(can_be), .can_addr(can_addr),
    .can_wdata(can_wdata), .can_rdata(can_rdata), .can_rdy(can_rdy),
    .buf_busy(buf_busy)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  task automatic check(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL R3 watchdog expired act=%0d exp=%0d", cyc, 20000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  typedef struct packed {
    logic        is_can;
    logic        we;
    logic [1:0]  be;
    logic [7:0]  addr;
    logic [15:0] wdata;
    logic [14:0] busy;
    logic        chk;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 2'b00, 8'h30, 16'h0000, 15'h0000, 1'b1, 16'h0000, 4'd12}, // R12 cleared store
    '{1'b0, 1'b1, 2'b11, 8'h09, 16'hA1B2, 15'h0000, 1'b0, 16'h0000, 4'd1 }, // R1 write
    '{1'b0, 1'b0, 2'b00, 8'h09, 16'h0000, 15'h0000, 1'b1, 16'hA1B2, 4'd1 }, // R1 readback
    '{1'b0, 1'b1, 2'b01, 8'h09, 16'hFFCC, 15'h0000, 1'b0, 16'h0000, 4'd2 }, // R2 low byte
    '{1'b0, 1'b0, 2'b00, 8'h09, 16'h0000, 15'h0000, 1'b1, 16'hA1CC, 4'd2 },
    '{1'b1, 1'b1, 2'b10, 8'h09, 16'h7700, 15'h0000, 1'b0, 16'h0000, 4'd2 }, // R2 high byte via CAN
    '{1'b0, 1'b0, 2'b00, 8'h09, 16'h0000, 15'h0000, 1'b1, 16'h77CC, 4'd2 },
    '{1'b0, 1'b1, 2'b11, 8'h0D, 16'h1234, 15'h0002, 1'b0, 16'h0000, 4'd6 }, // R6 busy payload write dropped
    '{1'b0, 1'b0, 2'b00, 8'h0D, 16'h0000, 15'h0002, 1'b1, 16'h0000, 4'd6 }, // R6 / R8 read while busy
    '{1'b0, 1'b1, 2'b11, 8'h0F, 16'h4455, 15'h0002, 1'b0, 16'h0000, 4'd6 }, // R6 identifier word dropped
    '{1'b0, 1'b0, 2'b00, 8'h0F, 16'h0000, 15'h0000, 1'b1, 16'h0000, 4'd6 },
    '{1'b0, 1'b1, 2'b11, 8'h08, 16'h5A3C, 15'h0002, 1'b0, 16'h0000, 4'd7 }, // R7 control word open
    '{1'b0, 1'b0, 2'b00, 8'h08, 16'h0000, 15'h0002, 1'b1, 16'h5A3C, 4'd7 }, // R7 / R8
    '{1'b0, 1'b1, 2'b11, 8'h0D, 16'h1234, 15'h0004, 1'b0, 16'h0000, 4'd6 }, // R6 other buffer busy
    '{1'b0, 1'b0, 2'b00, 8'h0D, 16'h0000, 15'h0004, 1'b1, 16'h1234, 4'd8 }, // R8
    '{1'b1, 1'b1, 2'b11, 8'h0D, 16'hBEEF, 15'h0002, 1'b0, 16'h0000, 4'd6 }, // R6 CAN not gated
    '{1'b0, 1'b0, 2'b00, 8'h0D, 16'h0000, 15'h0002, 1'b1, 16'hBEEF, 4'd6 },
    '{1'b0, 1'b1, 2'b11, 8'h78, 16'hFFFF, 15'h0000, 1'b0, 16'h0000, 4'd9 }, // R9 reserved bank
    '{1'b0, 1'b0, 2'b00, 8'h78, 16'h0000, 15'h0000, 1'b1, 16'h0000, 4'd9 },
    '{1'b0, 1'b1, 2'b11, 8'hC3, 16'hDEAD, 15'h0000, 1'b0, 16'h0000, 4'd9 }, // R9 beyond range
    '{1'b0, 1'b0, 2'b00, 8'hC3, 16'h0000, 15'h0000, 1'b1, 16'h0000, 4'd9 },
    '{1'b0, 1'b0, 2'b00, 8'h43, 16'h0000, 15'h0000, 1'b1, 16'h0000, 4'd9 }, // R9 no alias
    '{1'b1, 1'b1, 2'b11, 8'h7F, 16'hFFFF, 15'h0000, 1'b0, 16'h0000, 4'd9 },
    '{1'b1, 1'b0, 2'b00, 8'h7F, 16'h0000, 15'h0000, 1'b1, 16'h0000, 4'd9 },
    '{1'b0, 1'b1, 2'b11, 8'h77, 16'hCAFE, 15'h4000, 1'b0, 16'h0000, 4'd6 }, // R6 last buffer busy
    '{1'b0, 1'b1, 2'b11, 8'h77, 16'hCAFE, 15'h0000, 1'b0, 16'h0000, 4'd1 }, // R1 last word
    '{1'b1, 1'b0, 2'b00, 8'h77, 16'h0000, 15'h0000, 1'b1, 16'hCAFE, 4'd1 }
  };

  task automatic run_acc(input logic is_can, input logic we, input logic [1:0] be,
                         input logic [7:0] addr, input logic [15:0] wd,
                         output logic [15:0] rd, output int waits);
    if (is_can) begin
      can_req = 1'b1; can_we = we; can_be = be; can_addr = addr; can_wdata = wd;
    end else begin
      cpu_req = 1'b1; cpu_we = we; cpu_be = be; cpu_addr = addr; cpu_wdata = wd;
    end
    waits = 0;
    forever begin
      @(negedge clk);
      if (is_can ? can_rdy : cpu_rdy) break;
      waits++;
    end
    rd = is_can ? can_rdata : cpu_rdata;
    if (is_can) can_req = 1'b0; else cpu_req = 1'b0;
  endtask

  initial begin
    logic [15:0] rd;
    int          w;
    repeat (3) @(negedge clk);
    // R12 reset state
    check(cpu_rdy == 1'b0 && can_rdy == 1'b0, "R12 rdy", {14'h0, cpu_rdy, can_rdy}, 16'h0);
    check(cpu_rdata == 16'h0, "R12 cpu_rdata", cpu_rdata, 16'h0);
    check(can_rdata == 16'h0, "R12 can_rdata", can_rdata, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      buf_busy = VECS[i].busy;
      run_acc(VECS[i].is_can, VECS[i].we, VECS[i].be, VECS[i].addr, VECS[i].wdata, rd, w);
      // R3: no contention, ready in the cycle after the request
      check(w == 0, "R3 single-cycle", 16'(w), 16'h0);
      if (VECS[i].chk)
        check(rd == VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i), rd, VECS[i].exp);
      buf_busy = 15'h0;
    end

    // R4 / R5 contention: CAN holds its request for two cycles
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h09;
    can_req = 1'b1; can_we = 1'b1; can_be = 2'b11; can_addr = 8'h09; can_wdata = 16'h1111;
    @(negedge clk);
    check(can_rdy && !cpu_rdy, "R4 first tie", {14'h0, can_rdy, cpu_rdy}, 16'h2);
    can_wdata = 16'h2222;
    @(negedge clk);
    check(can_rdy && !cpu_rdy, "R4 second tie", {14'h0, can_rdy, cpu_rdy}, 16'h2);
    can_req = 1'b0;
    @(negedge clk);
    check(cpu_rdy && !can_rdy, "R4 cpu served when free", {14'h0, can_rdy, cpu_rdy}, 16'h1);
    check(cpu_rdata == 16'h2222, "R5 cpu sees latest CAN write", cpu_rdata, 16'h2222);
    cpu_req = 1'b0;
    @(negedge clk);
    check(!cpu_rdy, "R11 ready pulse ends", {15'h0, cpu_rdy}, 16'h0);

    // R10 processor read data holds across CAN traffic and idle cycles
    run_acc(1'b1, 1'b0, 2'b00, 8'h08, 16'h0, rd, w);
    check(rd == 16'h5A3C, "R8 CAN read control word", rd, 16'h5A3C);
    repeat (3) @(negedge clk);
    check(cpu_rdata == 16'h2222, "R10 cpu_rdata held", cpu_rdata, 16'h2222);
    check(!cpu_rdy && !can_rdy, "R11 no ready when idle", {14'h0, can_rdy, cpu_rdy}, 16'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule